// File: doc/BRIEF.md
# Burst-Gated DMA Read Mover

This block takes one transfer command at a time and turns it into read requests on a memory-mapped read port. Each command gives a byte start address, a length in data words, a flag that selects an incrementing or a fixed address, and a flag that turns on packet markers. The returned words go into a small internal buffer. From there they leave through a valid/ready stream that carries start and end markers. When every word of a command has left the block, a one-cycle status pulse reports how many words were moved.

With bursting on, requests are grouped into bursts of up to `MAX_BURST` words. The internal buffer holds twice that many words. A burst is issued only if the words already buffered, plus the words requested but not yet returned, plus the new burst, all fit in the buffer. The read port therefore never has to be stalled on its return path. The final burst of a command is shortened to the words that remain. In fixed-address mode every request is a single word at the command address.

Top module: `dma_read_mover`

## Requirements
- R1: While reset is asserted, cmd_ready is 1 and rd_req, out_valid and sts_valid are 0.
- R2: After a command of nonzero length is accepted, cmd_ready stays 0 until the cycle in which sts_valid is 1 for that command.
- R3: A request is granted only if buffered words, plus outstanding words, plus rd_burst, total at most 2*MAX_BURST (8 by default). If the output is held off during a long command, that total settles at exactly 8 and rd_req goes to 0.
- R4: With cmd_incr=1, each rd_burst equals the smaller of MAX_BURST and the words not yet requested, so the last burst is shortened. Each rd_addr equals cmd_addr plus 4 times the number of words already requested, with 32-bit words.
- R5: With cmd_incr=0, every request has rd_burst=1 and rd_addr equal to cmd_addr.
- R6: While rd_req is 1 and rd_gnt is 0, on the next cycle rd_req is still 1 and rd_addr and rd_burst are unchanged.
- R7: Output word k of a command is the k-th word returned on rd_rdata, with no loss, no repeat and no reordering.
- R8: With cmd_mark=1, out_sop is 1 only on word 0 and out_eop is 1 only on word len-1 (both on a one-word command). With cmd_mark=0, both are 0.
- R9: sts_valid is 1 for one cycle, the cycle after the handshake of the final output word, with sts_words equal to the command length.
- R10: A zero-length command is accepted and makes no read request. sts_valid is 1 in the following cycle with sts_words=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | LW | Length in words |
| cmd_incr | input | 1 | 1: incrementing address, 0: fixed address |
| cmd_mark | input | 1 | Generate start and end markers |
| rd_req | output | 1 | Read request valid |
| rd_gnt | input | 1 | Read request taken this cycle |
| rd_addr | output | AW | Request byte address |
| rd_burst | output | BCW | Request length in words |
| rd_rvalid | input | 1 | Returned word valid, always accepted |
| rd_rdata | input | DW | Returned word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | DW | Output word |
| out_sop | output | 1 | First word of a marked command |
| out_eop | output | 1 | Last word of a marked command |
| sts_valid | output | 1 | Command complete pulse |
| sts_words | output | LW | Words moved by the completed command |

## Verification
A request depends only on registered state, so it is checked in the same cycle it is presented, together with the grant that accepts it. A returned word can reach out_data at the earliest one cycle after the edge that captures it. The status pulse is due exactly one cycle after the last output handshake, or one cycle after a zero-length command is accepted. The bench drives inputs on the falling edge and reads outputs a short delay later. It records the handshakes that the next rising edge will complete, and checks the status pulse at the following falling edge, where the one-cycle register delay places it.

// File: rtl/dma_read_mover.sv
module dma_read_mover #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16,
  parameter int MAX_BURST = 4,
  parameter bit BURST_EN = 1'b1,
  localparam int MB = BURST_EN ? MAX_BURST : 1,
  localparam int BCW = $clog2(MB + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [LW-1:0]  cmd_len,
  input  logic           cmd_incr,
  input  logic           cmd_mark,
  output logic           rd_req,
  input  logic           rd_gnt,
  output logic [AW-1:0]  rd_addr,
  output logic [BCW-1:0] rd_burst,
  input  logic           rd_rvalid,
  input  logic [DW-1:0]  rd_rdata,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_sop,
  output logic           out_eop,
  output logic           sts_valid,
  output logic [LW-1:0]  sts_words
);
  localparam int DEPTH = 2 * MB;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BYTES = DW / 8;

  logic          busy, incr_q, mark_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q, left_q, done_q;
  logic [DW-1:0] buf_q [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] occ, infl;
  logic [BCW-1:0] blen;
  logic accept, grant, pop, last_pop, room;

  always_comb begin
    if (!incr_q) blen = BCW'(1);
    else if (left_q >= LW'(MB)) blen = BCW'(MB);
    else blen = left_q[BCW-1:0];
  end

  assign room = ({1'b0, occ} + {1'b0, infl} + (CW+1)'(blen)) <= (CW+1)'(DEPTH);

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign rd_req    = busy && (left_q != '0) && room;
  assign grant     = rd_req && rd_gnt;
  assign rd_addr   = addr_q;
  assign rd_burst  = blen;

  assign out_valid = (occ != '0);
  assign out_data  = buf_q[rp];
  assign pop       = out_valid && out_ready;
  assign last_pop  = pop && (done_q == len_q - LW'(1));
  assign out_sop   = mark_q && (done_q == '0);
  assign out_eop   = mark_q && (done_q == len_q - LW'(1));

  always_ff @(posedge clk)
    if (rd_rvalid) buf_q[wp] <= rd_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      incr_q    <= 1'b0;
      mark_q    <= 1'b0;
      addr_q    <= '0;
      len_q     <= '0;
      left_q    <= '0;
      done_q    <= '0;
      wp        <= '0;
      rp        <= '0;
      occ       <= '0;
      infl      <= '0;
      sts_valid <= 1'b0;
      sts_words <= '0;
    end else begin
      sts_valid <= 1'b0;
      if (accept) begin
        addr_q <= cmd_addr;
        incr_q <= cmd_incr;
        mark_q <= cmd_mark;
        len_q  <= cmd_len;
        left_q <= cmd_len;
        done_q <= '0;
        busy   <= (cmd_len != '0);
        if (cmd_len == '0) begin
          sts_valid <= 1'b1;
          sts_words <= '0;
        end
      end
      if (grant) begin
        left_q <= left_q - LW'(blen);
        if (incr_q) addr_q <= addr_q + AW'(blen) * AW'(BYTES);
      end
      if (pop) begin
        done_q <= done_q + LW'(1);
        rp     <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      end
      if (last_pop) begin
        busy      <= 1'b0;
        sts_valid <= 1'b1;
        sts_words <= len_q;
      end
      if (rd_rvalid) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      occ  <= occ + CW'(rd_rvalid) - CW'(pop);
      infl <= infl + (grant ? CW'(blen) : CW'(0)) - CW'(rd_rvalid);
    end
  end
endmodule

// File: rtl/dma_read_mover_chk.sv
module dma_read_mover_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int MB = 4,
  parameter int BCW = 3,
  parameter int CW = 4,
  parameter int DEPTH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           cmd_ready,
  input logic [LW-1:0]  cmd_len,
  input logic           rd_req,
  input logic           rd_gnt,
  input logic [AW-1:0]  rd_addr,
  input logic [BCW-1:0] rd_burst,
  input logic           incr_q,
  input logic [CW-1:0]  occ,
  input logic [CW-1:0]  infl,
  input logic           sts_valid,
  input logic           out_valid
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (int'(occ) + int'(infl)) <= DEPTH); // R3
  AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> (rd_burst != '0) && (int'(rd_burst) <= MB)); // R4
  AST_FIXED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !incr_q) |-> (rd_burst == BCW'(1))); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && !rd_gnt) |=> rd_req && $stable(rd_addr) && $stable(rd_burst)); // R6
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready && cmd_len != '0) |=> !cmd_ready); // R2
  AST_STS_DRAINED: assert property (@(posedge clk) disable iff (!rst_n) sts_valid |-> !out_valid); // R9
endmodule

bind dma_read_mover dma_read_mover_chk #(
  .AW(AW), .LW(LW), .MB(MB), .BCW(BCW), .CW(CW), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr),
  .rd_burst(rd_burst), .incr_q(incr_q), .occ(occ), .infl(infl),
  .sts_valid(sts_valid), .out_valid(out_valid)
);

// File: tb/dma_read_mover_tb.sv
`timescale 1ns/1ps
module dma_read_mover_tb_top;
  localparam int MB = 4;
  localparam int DEPTH = 2 * MB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_incr = 1'b0, cmd_mark = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [15:0] cmd_len = '0;
  logic rd_gnt = 1'b0, rd_rvalid = 1'b0, out_ready = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic cmd_ready, rd_req, out_valid, out_sop, out_eop, sts_valid;
  logic [31:0] rd_addr, out_data;
  logic [2:0] rd_burst;
  logic [15:0] sts_words;

  always #2.5 clk = ~clk;

  dma_read_mover dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_incr(cmd_incr), .cmd_mark(cmd_mark),
    .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr), .rd_burst(rd_burst),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .sts_valid(sts_valid), .sts_words(sts_words)
  );

  int checks = 0, fails = 0;
  int rdy_pct = 100, gnt_pct = 100;
  bit busy_b = 0, sts_due = 0, acc_now = 0;
  int sts_exp = 0, issued = 0, outk = 0, outst = 0, bufd = 0;
  logic [31:0] e_base = '0;
  int e_len = 0;
  bit e_incr = 0, e_mark = 0;
  logic [31:0] beatq[$];

  function automatic logic [31:0] memf(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic int exp_burst(bit inc, int left);
    if (!inc) return 1;
    return (left < MB) ? left : MB;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    rd_gnt = ($urandom % 100) < gnt_pct;
    out_ready = ($urandom % 100) < rdy_pct;
    if (beatq.size() > 0 && ($urandom % 100) < 75) begin
      rd_rvalid = 1'b1;
      rd_rdata = memf(beatq.pop_front());
    end else begin
      rd_rvalid = 1'b0;
      rd_rdata = '0;
    end
    #1;
    if (sts_due) begin
      chk(sts_valid === 1'b1, "R9", "status pulse due", sts_valid, 1);
      chk(sts_words == 16'(sts_exp), e_len == 0 ? "R10" : "R9", "status words", sts_words, sts_exp);
      sts_due = 0;
      busy_b = 0;
    end else if (sts_valid) begin
      chk(1'b0, "R9", "unexpected status pulse", 1, 0);
    end
    if (busy_b && cmd_ready) chk(1'b0, "R2", "cmd_ready while busy", 1, 0);
    if (rd_req) begin
      if (!busy_b || issued >= e_len) begin
        chk(1'b0, "R10", "request with nothing left", issued, e_len);
      end else begin
        chk(rd_burst == 3'(exp_burst(e_incr, e_len - issued)), e_incr ? "R4" : "R5",
            "burst length", rd_burst, exp_burst(e_incr, e_len - issued));
        chk(rd_addr == (e_incr ? e_base + 32'(4 * issued) : e_base), e_incr ? "R4" : "R5",
            "request address", rd_addr, e_incr ? e_base + 32'(4 * issued) : e_base);
        if (rd_gnt) begin
          chk(outst + bufd + int'(rd_burst) <= DEPTH, "R3", "space at grant",
              outst + bufd + int'(rd_burst), DEPTH);
          for (int i = 0; i < int'(rd_burst); i++) beatq.push_back(rd_addr + 32'(4 * i));
          outst += int'(rd_burst);
          issued += int'(rd_burst);
        end
      end
    end
    if (rd_rvalid) begin
      outst--;
      bufd++;
    end
    if (out_valid && out_ready) begin
      logic [31:0] ew;
      ew = memf(e_incr ? e_base + 32'(4 * outk) : e_base);
      chk(out_data == ew, "R7", "output word", out_data, ew);
      chk(out_sop == (e_mark && outk == 0), "R8", "sop", out_sop, e_mark && outk == 0);
      chk(out_eop == (e_mark && outk == e_len - 1), "R8", "eop", out_eop, e_mark && outk == e_len - 1);
      bufd--;
      outk++;
      if (outk == e_len) begin
        sts_due = 1;
        sts_exp = e_len;
      end
    end
    acc_now = cmd_valid && cmd_ready;
    if (acc_now) begin
      e_base = cmd_addr;
      e_len = int'(cmd_len);
      e_incr = cmd_incr;
      e_mark = cmd_mark;
      issued = 0;
      outk = 0;
      if (cmd_len == 0) begin
        sts_due = 1;
        sts_exp = 0;
      end else busy_b = 1;
    end
  end

  task automatic send(input logic [31:0] a, input int len, input bit inc, input bit mk);
    @(negedge clk);
    cmd_addr = a;
    cmd_len = 16'(len);
    cmd_incr = inc;
    cmd_mark = mk;
    cmd_valid = 1'b1;
    do @(posedge clk); while (!acc_now);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy_b || sts_due) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(cmd_ready === 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
    chk(rd_req === 1'b0, "R1", "rd_req in reset", rd_req, 0);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    chk(sts_valid === 1'b0, "R1", "sts_valid in reset", sts_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    send(32'h0000_1000, 1, 1'b1, 1'b1);   // R8 single word carries both markers
    send(32'h0000_2000, 4, 1'b1, 1'b1);   // R4 exact burst
    send(32'h0000_3000, 5, 1'b1, 1'b1);   // R4 shortened last burst
    send(32'h0000_4000, 6, 1'b0, 1'b1);   // R5 fixed address
    send(32'h0000_5000, 0, 1'b1, 1'b1);   // R10 zero length
    gnt_pct = 40;
    rdy_pct = 70;
    send(32'hFFFF_FFF0, 9, 1'b1, 1'b0);   // R6 R8 address wrap, no markers
    rdy_pct = 0;
    gnt_pct = 100;
    fork
      send(32'h0000_8000, 40, 1'b1, 1'b1);
      begin
        repeat (60) @(negedge clk);
        #2;
        chk(outst + bufd == DEPTH, "R3", "stalled fill level", outst + bufd, DEPTH);
        chk(rd_req === 1'b0, "R3", "no request when full", rd_req, 0);
        rdy_pct = 60;
      end
    join
    for (int n = 0; n < 30; n++) begin
      gnt_pct = 30 + int'($urandom % 71);
      rdy_pct = 30 + int'($urandom % 71);
      send($urandom & 32'hFFFF_FFFC, int'($urandom % 13), 1'($urandom), 1'($urandom));
    end
    repeat (5) @(negedge clk);
    #2;
    chk(beatq.size() == 0 && outst == 0 && bufd == 0, "R7", "all words delivered once",
        outst + bufd, 0);
    summary();
  end
endmodule